// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Unit

This block sits between a source controller and one processor. It holds a 32-bit presentation word: the processor's current priority in bits 31:24 and a pending source number in bits 23:0, where a zero source number means nothing is pending. Beside the word it keeps the priority of the pending interrupt and the priority of a software-raised inter-processor message (IPI). A smaller number is a more favoured priority, and 0xFF is the least favoured value.

The source controller offers interrupts one at a time. The unit either takes an offer or bounces it straight back. When a better offer or the IPI displaces a pending interrupt from the source controller, the displaced source number is handed back so that it can be offered again later. The processor accepts the pending interrupt, can lower or raise its current priority, can set the IPI priority, and signals end of interrupt. The unit forwards end-of-interrupt source numbers to the source controller.

Top module: `irq_presenter`

## Requirements
- R1: After reset, `pres_word` is 0x00000000, the pending priority is 0xFF, the IPI priority is 0xFF, and `cpu_irq`, `disp_valid`, `nack_valid` and `eoi_valid` are all low.
- R2: An offer is taken when its priority is strictly below the current priority (bits 31:24) and either nothing is pending or it is strictly below the pending priority. On the next cycle bits 23:0 hold the offered source and `cpu_irq` is high.
- R3: An offer that fails the test of R2 leaves the word unchanged. On the next cycle it is returned on `nack_valid`/`nack_src` for exactly one cycle.
- R4: When a taken offer or the IPI replaces a pending source that came from the source controller, the old source number appears on `disp_valid`/`disp_src` for one cycle. The new source is loaded in the same cycle.
- R5: An accept captures the whole word in `ack_word` and drops `cpu_irq`. It loads the old pending priority into bits 31:24, clears bits 23:0 and sets the pending priority to 0xFF.
- R6: A current-priority write of a value smaller than the present one, made while something is pending whose priority is not strictly smaller than the new value, clears the pending source. It also sets the pending priority to 0xFF, drops `cpu_irq` and displaces the source as in R4. If the pending priority is strictly smaller, the pending interrupt stays.
- R7: After an IPI-priority write, a current-priority write or an end of interrupt, the IPI is loaded as source number 2 with the IPI priority if that priority is strictly below the current priority and either nothing is pending or it is strictly below the pending priority.
- R8: Source number 2 (the IPI) is never sent on `disp_src`, whether it is displaced by an offer or cleared by a current-priority write.
- R9: An end-of-interrupt write copies bits 31:24 of `eoi_data` into the current priority. If bits 23:0 are neither 0 nor 2, they are sent on `eoi_valid`/`eoi_src` for one cycle.
- R10: Only one operation is processed per cycle, with ranking accept, current-priority write, IPI-priority write, end of interrupt, then offer. Lower-ranked writes in that cycle have no effect, and an offer that loses is returned as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Source controller offers an interrupt this cycle |
| offer_src | input | 24 | Offered source number |
| offer_pri | input | 8 | Offered priority |
| cppr_wr | input | 1 | Current-priority write strobe |
| cppr_data | input | 8 | New current priority |
| ipi_wr | input | 1 | IPI-priority write strobe |
| ipi_data | input | 8 | New IPI priority |
| accept | input | 1 | Processor accepts the pending interrupt |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | 32 | Priority to restore (31:24) and finished source (23:0) |
| cpu_irq | output | 1 | Level interrupt request to the processor |
| pres_word | output | 32 | Present {current priority, pending source} |
| ack_word | output | 32 | Word captured by the last accept |
| disp_valid | output | 1 | One-cycle pulse: pending source displaced back to the source controller |
| disp_src | output | 24 | Displaced source number |
| nack_valid | output | 1 | One-cycle pulse: offer refused |
| nack_src | output | 24 | Refused source number |
| eoi_valid | output | 1 | One-cycle end-of-interrupt notification |
| eoi_src | output | 24 | Source number that finished |

## Verification
The bench checks the strict-inequality boundaries, where offers or priority writes land exactly on the current or pending priority. A design using less-or-equal there would take a tied offer or keep a pending interrupt that should have been cleared. It checks that the IPI source is never handed back and that an end of interrupt for source 2 or 0 produces no notification. A design that treats the IPI as an ordinary source would emit bogus rejects that make the source controller resend a nonexistent interrupt. It also drives colliding operations in one cycle and checks that the losing offer is bounced and the losing write has no effect. It checks that a raised priority after end of interrupt re-presents a waiting IPI, which a design without the re-check would leave unserved.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    // Operation chosen for a cycle, listed from highest to lowest rank.
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_ACCEPT = 3'd1,
        OP_CPPR   = 3'd2,
        OP_IPI    = 3'd3,
        OP_EOI    = 3'd4,
        OP_OFFER  = 3'd5
    } irqp_op_t;

endpackage

// File: rtl/irqp_op_select.sv
module irqp_op_select
    import irqp_pkg::*;
(
    input  logic     accept,
    input  logic     cppr_wr,
    input  logic     ipi_wr,
    input  logic     eoi_wr,
    input  logic     offer_valid,
    output irqp_op_t op
);

    // Fixed ranking: the first active request wins the cycle.
    always_comb begin
        if (accept)           op = OP_ACCEPT;
        else if (cppr_wr)     op = OP_CPPR;
        else if (ipi_wr)      op = OP_IPI;
        else if (eoi_wr)      op = OP_EOI;
        else if (offer_valid) op = OP_OFFER;
        else                  op = OP_NONE;
    end

endmodule

// File: rtl/irqp_favour.sv
module irqp_favour #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] cand_pri,
    input  logic [PRIO_W-1:0] cur_pri,
    input  logic              pend_busy,
    input  logic [PRIO_W-1:0] pend_pri,
    output logic              wins
);

    // A candidate must beat the processor priority and any pending one.
    always_comb begin
        wins = (cand_pri < cur_pri) && (!pend_busy || (cand_pri < pend_pri));
    end

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irqp_pkg::*;
#(
    parameter int PRIO_W  = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      offer_valid,
    input  logic [SRC_W-1:0]          offer_src,
    input  logic [PRIO_W-1:0]         offer_pri,
    input  logic                      cppr_wr,
    input  logic [PRIO_W-1:0]         cppr_data,
    input  logic                      ipi_wr,
    input  logic [PRIO_W-1:0]         ipi_data,
    input  logic                      accept,
    input  logic                      eoi_wr,
    input  logic [PRIO_W+SRC_W-1:0]   eoi_data,
    output logic                      cpu_irq,
    output logic [PRIO_W+SRC_W-1:0]   pres_word,
    output logic [PRIO_W+SRC_W-1:0]   ack_word,
    output logic                      disp_valid,
    output logic [SRC_W-1:0]          disp_src,
    output logic                      nack_valid,
    output logic [SRC_W-1:0]          nack_src,
    output logic                      eoi_valid,
    output logic [SRC_W-1:0]          eoi_src
);

    localparam int                WORD_W    = PRIO_W + SRC_W;
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
    localparam logic [SRC_W-1:0]  IPI_ID    = SRC_W'(IPI_SRC);
    localparam logic [SRC_W-1:0]  SRC_NONE  = '0;

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic [SRC_W-1:0]  xsrc;
        logic [PRIO_W-1:0] pend;
        logic [PRIO_W-1:0] mfrr;
        logic              from_src;
        logic              irq;
        logic [WORD_W-1:0] ack;
        logic              disp_v;
        logic [SRC_W-1:0]  disp_s;
        logic              nack_v;
        logic [SRC_W-1:0]  nack_s;
        logic              eoi_v;
        logic [SRC_W-1:0]  eoi_s;
    } state_t;

    state_t   st_q, mid_d, st_d;
    irqp_op_t op;
    logic     ipi_wins, offer_wins, rechk_ipi;

    irqp_op_select u_sel (
        .accept      (accept),
        .cppr_wr     (cppr_wr),
        .ipi_wr      (ipi_wr),
        .eoi_wr      (eoi_wr),
        .offer_valid (offer_valid),
        .op          (op)
    );

    // Offers are judged against the registered state.
    irqp_favour #(.PRIO_W(PRIO_W)) u_offer_fav (
        .cand_pri  (offer_pri),
        .cur_pri   (st_q.cppr),
        .pend_busy (st_q.xsrc != SRC_NONE),
        .pend_pri  (st_q.pend),
        .wins      (offer_wins)
    );

    // The IPI is judged against the state after this cycle's write.
    irqp_favour #(.PRIO_W(PRIO_W)) u_ipi_fav (
        .cand_pri  (mid_d.mfrr),
        .cur_pri   (mid_d.cppr),
        .pend_busy (mid_d.xsrc != SRC_NONE),
        .pend_pri  (mid_d.pend),
        .wins      (ipi_wins)
    );

    // Stage one: processor-side operations.
    always_comb begin
        mid_d        = st_q;
        mid_d.disp_v = 1'b0;
        mid_d.disp_s = SRC_NONE;
        mid_d.nack_v = 1'b0;
        mid_d.nack_s = SRC_NONE;
        mid_d.eoi_v  = 1'b0;
        mid_d.eoi_s  = SRC_NONE;
        unique case (op)
            OP_ACCEPT: begin
                mid_d.ack      = {st_q.cppr, st_q.xsrc};
                mid_d.cppr     = st_q.pend;
                mid_d.xsrc     = SRC_NONE;
                mid_d.pend     = PRIO_NONE;
                mid_d.from_src = 1'b0;
            end
            OP_CPPR: begin
                mid_d.cppr = cppr_data;
                if ((cppr_data < st_q.cppr) && (st_q.xsrc != SRC_NONE)
                    && (cppr_data <= st_q.pend)) begin
                    mid_d.xsrc     = SRC_NONE;
                    mid_d.pend     = PRIO_NONE;
                    mid_d.from_src = 1'b0;
                    if (st_q.from_src) begin
                        mid_d.disp_v = 1'b1;
                        mid_d.disp_s = st_q.xsrc;
                    end
                end
            end
            OP_IPI: begin
                mid_d.mfrr = ipi_data;
            end
            OP_EOI: begin
                mid_d.cppr = eoi_data[WORD_W-1 -: PRIO_W];
                if ((eoi_data[SRC_W-1:0] != SRC_NONE)
                    && (eoi_data[SRC_W-1:0] != IPI_ID)) begin
                    mid_d.eoi_v = 1'b1;
                    mid_d.eoi_s = eoi_data[SRC_W-1:0];
                end
            end
            default: ;
        endcase
    end

    assign rechk_ipi = (op == OP_CPPR) || (op == OP_IPI) || (op == OP_EOI);

    // Stage two: IPI re-check and offers.
    always_comb begin
        st_d = mid_d;
        if (rechk_ipi && ipi_wins) begin
            if ((mid_d.xsrc != SRC_NONE) && mid_d.from_src) begin
                st_d.disp_v = 1'b1;
                st_d.disp_s = mid_d.xsrc;
            end
            st_d.xsrc     = IPI_ID;
            st_d.pend     = mid_d.mfrr;
            st_d.from_src = 1'b0;
        end
        if (op == OP_OFFER) begin
            if (offer_wins) begin
                if ((st_q.xsrc != SRC_NONE) && st_q.from_src) begin
                    st_d.disp_v = 1'b1;
                    st_d.disp_s = st_q.xsrc;
                end
                st_d.xsrc     = offer_src;
                st_d.pend     = offer_pri;
                st_d.from_src = 1'b1;
            end else begin
                st_d.nack_v = 1'b1;
                st_d.nack_s = offer_src;
            end
        end else if (offer_valid) begin
            st_d.nack_v = 1'b1;
            st_d.nack_s = offer_src;
        end
        st_d.irq = (st_d.xsrc != SRC_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.pend     <= PRIO_NONE;
            st_q.mfrr     <= PRIO_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_irq    = st_q.irq;
    assign pres_word  = {st_q.cppr, st_q.xsrc};
    assign ack_word   = st_q.ack;
    assign disp_valid = st_q.disp_v;
    assign disp_src   = st_q.disp_s;
    assign nack_valid = st_q.nack_v;
    assign nack_src   = st_q.nack_s;
    assign eoi_valid  = st_q.eoi_v;
    assign eoi_src    = st_q.eoi_s;

    // R2: the line follows the presence of a pending source in the word.
    assert_line_matches_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (pres_word[SRC_W-1:0] != SRC_NONE));

    // R8: neither the IPI nor an empty slot is ever displaced.
    assert_no_ipi_displace_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_src != IPI_ID) && (disp_src != SRC_NONE));

    // R3: a refusal only follows an offer.
    assert_nack_follows_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nack_valid |-> ($past(offer_valid) && (nack_src == $past(offer_src))));

    // R5: an accept always drops the line.
    assert_accept_drops_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !cpu_irq);

    // R9: an uncontested end of interrupt restores the written priority.
    assert_eoi_restores_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !accept && !cppr_wr && !ipi_wr)
        |=> (pres_word[WORD_W-1 -: PRIO_W] == $past(eoi_data[WORD_W-1 -: PRIO_W])));

    // R10: a notification only follows an end of interrupt that won its cycle.
    assert_eoi_needs_win_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> ($past(eoi_wr) && !$past(accept) && !$past(cppr_wr) && !$past(ipi_wr)));

endmodule

// File: tb/irq_presenter_test.sv
module irq_presenter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_pri = '0;
    logic        cppr_wr = 1'b0;
    logic [7:0]  cppr_data = '0;
    logic        ipi_wr = 1'b0;
    logic [7:0]  ipi_data = '0;
    logic        accept = 1'b0;
    logic        eoi_wr = 1'b0;
    logic [31:0] eoi_data = '0;
    logic        cpu_irq;
    logic [31:0] pres_word;
    logic [31:0] ack_word;
    logic        disp_valid;
    logic [23:0] disp_src;
    logic        nack_valid;
    logic [23:0] nack_src;
    logic        eoi_valid;
    logic [23:0] eoi_src;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_presenter uut (
        .clk(clk), .rst_n(rst_n),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_pri(offer_pri),
        .cppr_wr(cppr_wr), .cppr_data(cppr_data),
        .ipi_wr(ipi_wr), .ipi_data(ipi_data),
        .accept(accept), .eoi_wr(eoi_wr), .eoi_data(eoi_data),
        .cpu_irq(cpu_irq), .pres_word(pres_word), .ack_word(ack_word),
        .disp_valid(disp_valid), .disp_src(disp_src),
        .nack_valid(nack_valid), .nack_src(nack_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        offer_valid = 1'b0; cppr_wr = 1'b0; ipi_wr = 1'b0;
        accept = 1'b0; eoi_wr = 1'b0;
    endtask

    // Drive what is set, take one edge, leave outputs ready to sample.
    task automatic tick();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic set_offer(input logic [23:0] s, input logic [7:0] p);
        offer_valid = 1'b1; offer_src = s; offer_pri = p;
    endtask

    task automatic t_reset();
        chk("R1 word", pres_word, 32'h0);
        chk("R1 irq", {31'b0, cpu_irq}, 32'h0);
        chk("R1 pulses", {29'b0, disp_valid, nack_valid, eoi_valid}, 32'h0);
    endtask

    task automatic t_refuse_and_take();
        set_offer(24'h100, 8'h05); tick();
        chk("R3 refused at cppr 0", {7'b0, nack_valid, nack_src}, {8'h01, 24'h100});
        chk("R3 word unchanged", pres_word, 32'h0);
        cppr_wr = 1'b1; cppr_data = 8'h80; tick();
        chk("R7 no ipi at FF", pres_word, 32'h80000000);
        set_offer(24'h10, 8'h40); tick();
        chk("R2 taken", pres_word, 32'h80000010);
        chk("R2 irq", {31'b0, cpu_irq}, 32'h1);
        chk("R2 no nack", {31'b0, nack_valid}, 32'h0);
        set_offer(24'h11, 8'h40); tick();
        chk("R3 tie with pending", {7'b0, nack_valid, nack_src}, {8'h01, 24'h11});
        chk("R3 kept", pres_word, 32'h80000010);
        tick();
        chk("R3 pulse one cycle", {31'b0, nack_valid}, 32'h0);
    endtask

    task automatic t_displace();
        set_offer(24'h12, 8'h30); tick();
        chk("R4 displaced", {7'b0, disp_valid, disp_src}, {8'h01, 24'h10});
        chk("R4 loaded", pres_word, 32'h80000012);
        tick();
        chk("R4 pulse one cycle", {31'b0, disp_valid}, 32'h0);
    endtask

    task automatic t_accept_eoi();
        accept = 1'b1; tick();
        chk("R5 ack word", ack_word, 32'h80000012);
        chk("R5 word", pres_word, 32'h30000000);
        chk("R5 irq low", {31'b0, cpu_irq}, 32'h0);
        eoi_wr = 1'b1; eoi_data = 32'h80000012; tick();
        chk("R9 eoi fwd", {7'b0, eoi_valid, eoi_src}, {8'h01, 24'h12});
        chk("R9 cppr", pres_word, 32'h80000000);
    endtask

    task automatic t_cppr_eject();
        set_offer(24'h20, 8'h50); tick();
        chk("R2 second take", pres_word, 32'h80000020);
        cppr_wr = 1'b1; cppr_data = 8'h60; tick();
        chk("R6 kept when better", pres_word, 32'h60000020);
        chk("R6 no disp", {31'b0, disp_valid}, 32'h0);
        cppr_wr = 1'b1; cppr_data = 8'h50; tick();
        chk("R6 ejected", {7'b0, disp_valid, disp_src}, {8'h01, 24'h20});
        chk("R6 word", pres_word, 32'h50000000);
        chk("R6 irq low", {31'b0, cpu_irq}, 32'h0);
    endtask

    task automatic t_ipi();
        ipi_wr = 1'b1; ipi_data = 8'h40; tick();
        chk("R7 ipi loaded", pres_word, 32'h50000002);
        chk("R7 irq", {31'b0, cpu_irq}, 32'h1);
        set_offer(24'h21, 8'h30); tick();
        chk("R8 ipi not rejected", {31'b0, disp_valid}, 32'h0);
        chk("R8 offer over ipi", pres_word, 32'h50000021);
        ipi_wr = 1'b1; ipi_data = 8'h20; tick();
        chk("R7 ipi displaces ext", {7'b0, disp_valid, disp_src}, {8'h01, 24'h21});
        chk("R7 word", pres_word, 32'h50000002);
        cppr_wr = 1'b1; cppr_data = 8'h10; tick();
        chk("R8 ipi eject silent", {31'b0, disp_valid}, 32'h0);
        chk("R8 word", pres_word, 32'h10000000);
        eoi_wr = 1'b1; eoi_data = 32'hFF000002; tick();
        chk("R9 no eoi for ipi", {31'b0, eoi_valid}, 32'h0);
        chk("R7 recheck after eoi", pres_word, 32'hFF000002);
        accept = 1'b1; tick();
        chk("R5 ack ipi", ack_word, 32'hFF000002);
        chk("R5 cppr from pend", pres_word, 32'h20000000);
        ipi_wr = 1'b1; ipi_data = 8'hFF; tick();
        chk("R7 no ipi when worse", pres_word, 32'h20000000);
    endtask

    task automatic t_collide();
        accept = 1'b1; set_offer(24'h30, 8'h05); tick();
        chk("R10 accept wins", ack_word, 32'h20000000);
        chk("R10 offer bounced", {7'b0, nack_valid, nack_src}, {8'h01, 24'h30});
        chk("R10 empty accept", pres_word, 32'hFF000000);
        cppr_wr = 1'b1; cppr_data = 8'h70;
        eoi_wr = 1'b1; eoi_data = 32'h11000044; tick();
        chk("R10 cppr beats eoi", pres_word, 32'h70000000);
        chk("R10 eoi dropped", {31'b0, eoi_valid}, 32'h0);
        eoi_wr = 1'b1; eoi_data = 32'h90000000; tick();
        chk("R9 src 0 silent", {31'b0, eoi_valid}, 32'h0);
        chk("R9 cppr only", pres_word, 32'h90000000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_refuse_and_take();
        t_displace();
        t_accept_eoi();
        t_cppr_eject();
        t_ipi();
        t_collide();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule